// File: doc/BRIEF.md
# Paged Peripheral Window Bus Decoder

This block sits on the 8-bit I/O bus of an add-in board and has two jobs. It decodes a bank of eight board registers, and it opens a 32-byte window onto an external controller that has 128 registers. Two strap inputs place the bank at one of four 8-byte slots. The bank returns two identification bytes, a version byte and the strap state. It also holds an LED bit, a 2-bit page register and a mode register.

When the mode register's window-enable bit is set, bus accesses that land in the selected 32-byte window go straight through to the controller. The chip-select, the strobes and the write data pass unchanged. The page bits are prepended to the five low address bits to form the controller's 7-bit register address. If an address falls in both the bank and the enabled window, the bank wins.

The block also steers the controller's interrupt onto one of three interrupt lines, chosen by two further straps. Lines 6 and 7 can run in a shared, open-drain style, where the line is driven only while the interrupt is pending. The bus interface uses plain strobes: reads are combinational within the strobe cycle, and writes take effect at the clock edge that ends the write cycle. There is no back-pressure, so every access completes in one cycle.

Top module: `pagewin_bus_decoder`

## Requirements
- R1: The bank occupies bus addresses 0x150 + 8·{strap[1],strap[0]} through that value + 7. A read there asserts bus_rd_en. Addresses outside the bank and outside an enabled window give bus_rd_en=0 and bus_rdata=0.
- R2: The bank offsets 0, 1 and 2 read 0xF6, 0xB9 and the version constant (default 0x03). Writes to these offsets change no register.
- R3: Offset 3 bit 0 is the LED bit, driven on led_on (1 = lit). The other bits read 0.
- R4: Offset 4 bits 1:0 hold the page. Bits 7:2 read 0 and ignore writes.
- R5: Offset 5 holds these fields: window select in bits 2:0, interrupt share in bit 5 and window enable in bit 6. Bits 4:3 and 7 read 0.
- R6: Offset 6 reads {2'b00, strap[4:0], 1'b0}. Offset 7 reads 0. Writes to both are ignored.
- R7: After reset, the LED, page and mode registers are all 0, so led_on=0 and the window is closed.
- R8: With window enable set, an address in 0x100 + 0x20·select through +0x1F that is outside the bank asserts ctl_cs. The access then drives ctl_addr = {page, addr[4:0]}, ctl_rd/ctl_wr equal to the bus strobes, ctl_wdata = bus_wdata, and returns ctl_rdata on bus_rdata with bus_rd_en=1.
- R9: When the window is disabled, or the address is in the bank, ctl_cs, ctl_rd and ctl_wr stay 0.
- R10: The line vector bits [0],[1],[2] stand for interrupt lines 5, 6 and 7. {strap[4],strap[3]} selects the line: 00 selects none, 11 selects line 5, 01 selects line 6, 10 selects line 7. Without sharing, the selected line has irq_oe=1 and irq_lvl equal to ctl_irq as sampled at the previous clock edge. All other lines have irq_oe=0 and irq_lvl=0.
- R11: With the share bit set and line 6 or 7 selected, that line has irq_oe = irq_lvl = the sampled interrupt. The line is released when the interrupt is idle. The share bit has no effect on line 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 10 | I/O bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rd_en | output | 1 | Read data drive enable |
| strap | input | 5 | Jumper states 1..5, 1 = installed |
| led_on | output | 1 | LED drive |
| ctl_cs | output | 1 | Controller chip-select |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_addr | output | 7 | Controller register address |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data |
| ctl_irq | input | 1 | Controller interrupt, high when pending |
| irq_oe | output | 3 | Drive enable for lines 5/6/7 |
| irq_lvl | output | 3 | Driven level for lines 5/6/7 |

## Verification
A wrong page or mode value cannot stay hidden. It shows on the very next window access as a wrong ctl_addr or a missing ctl_cs, and a read of offset 4 or 5 shows it in the same cycle. A corrupted LED bit appears on led_on one clock after the bad write. A wrong interrupt selection or share state appears on irq_oe and irq_lvl one clock after ctl_irq changes. The random mix keeps strap, page and mode moving so that bank and window overlaps occur.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 8;
  localparam int PAGE_W  = 2;
  localparam int WIN_LOG = 5;
  localparam int BANK_LOG = 3;
  localparam int CTL_AW  = PAGE_W + WIN_LOG;
  localparam int N_LINES = 3;

  typedef enum logic [BANK_LOG-1:0] {
    OFF_ID0   = 3'd0,
    OFF_ID1   = 3'd1,
    OFF_VER   = 3'd2,
    OFF_LED   = 3'd3,
    OFF_PAGE  = 3'd4,
    OFF_MODE  = 3'd5,
    OFF_STRAP = 3'd6,
    OFF_SPARE = 3'd7
  } bank_off_e;

  typedef struct packed {
    logic       share;
    logic       win_en;
    logic [2:0] win_sel;
  } mode_t;
endpackage

// File: rtl/pw_addr_decode.sv
module pw_addr_decode
  import pw_pkg::*;
#(
  parameter int                BUS_AW    = ADDR_W,
  parameter logic [BUS_AW-1:0] BANK_BASE = 10'h150,
  parameter logic [BUS_AW-1:0] WIN_BASE  = 10'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] addr,
  input  logic [1:0]        base_sel,
  input  mode_t             mode,
  input  logic [PAGE_W-1:0] page,
  output logic              bank_hit,
  output bank_off_e         bank_off,
  output logic              win_hit,
  output logic [CTL_AW-1:0] ctl_addr
);
  localparam int HI = BUS_AW - 1;

  logic [BUS_AW-1:0] bank_start;
  logic [BUS_AW-1:0] win_start;
  logic              in_win;

  always_comb begin
    bank_start = BANK_BASE + (BUS_AW'(base_sel) << BANK_LOG);
    win_start  = WIN_BASE + (BUS_AW'(mode.win_sel) << WIN_LOG);
    bank_hit   = (addr[HI:BANK_LOG] == bank_start[HI:BANK_LOG]);
    bank_off   = bank_off_e'(addr[BANK_LOG-1:0]);
    in_win     = (addr[HI:WIN_LOG] == win_start[HI:WIN_LOG]);
    win_hit    = mode.win_en && in_win && !bank_hit;
    ctl_addr   = {page, addr[WIN_LOG-1:0]};
  end

  // R9
  bank_beats_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit |-> !win_hit);
endmodule

// File: rtl/pw_reg_bank.sv
module pw_reg_bank
  import pw_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID0     = 8'hF6,
  parameter logic [DATA_W-1:0] ID1     = 8'hB9,
  parameter logic [DATA_W-1:0] VERSION = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bank_off_e         off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [4:0]        strap,
  output logic              led,
  output logic [PAGE_W-1:0] page,
  output mode_t             mode,
  output logic [DATA_W-1:0] rdata
);
  logic              led_q;
  logic [PAGE_W-1:0] page_q;
  mode_t             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= 1'b0;
      page_q <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      case (off)
        OFF_LED:  led_q  <= wdata[0];
        OFF_PAGE: page_q <= wdata[PAGE_W-1:0];
        OFF_MODE: mode_q <= '{share: wdata[5], win_en: wdata[6], win_sel: wdata[2:0]};
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_ID0:   rdata = ID0;
      OFF_ID1:   rdata = ID1;
      OFF_VER:   rdata = VERSION;
      OFF_LED:   rdata = {{(DATA_W-1){1'b0}}, led_q};
      OFF_PAGE:  rdata = {{(DATA_W-PAGE_W){1'b0}}, page_q};
      OFF_MODE:  rdata = {1'b0, mode_q.win_en, mode_q.share, 2'b00, mode_q.win_sel};
      OFF_STRAP: rdata = {2'b00, strap, 1'b0};
      default:   rdata = '0;
    endcase
  end

  assign led  = led_q;
  assign page = page_q;
  assign mode = mode_q;

  // R3
  led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_LED) |=> led == $past(wdata[0]));
  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && off == OFF_PAGE) |=> $stable(page));
  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && off == OFF_MODE) |=> $stable(mode));
endmodule

// File: rtl/pw_irq_route.sv
module pw_irq_route
  import pw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_in,
  input  logic [1:0]         jsel,
  input  logic               share,
  output logic [N_LINES-1:0] irq_oe,
  output logic [N_LINES-1:0] irq_lvl
);
  logic               irq_q;
  logic [N_LINES-1:0] sel_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_in;
  end

  always_comb begin
    case (jsel)
      2'b11:   sel_vec = 3'b001;
      2'b01:   sel_vec = 3'b010;
      2'b10:   sel_vec = 3'b100;
      default: sel_vec = 3'b000;
    endcase
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    localparam bit SHAREABLE = (i != 0);
    logic od_mode;
    assign od_mode    = SHAREABLE && share;
    assign irq_oe[i]  = sel_vec[i] && (od_mode ? irq_q : 1'b1);
    assign irq_lvl[i] = sel_vec[i] && irq_q;
  end

  // R10
  irq_single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_oe));
  // R11
  share_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (share && jsel != 2'b11 && !$past(irq_in)) |-> irq_oe == '0);
endmodule

// File: rtl/pagewin_bus_decoder.sv
module pagewin_bus_decoder
  import pw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BANK_BASE = 10'h150,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 10'h100,
  parameter logic [DATA_W-1:0] ID0       = 8'hF6,
  parameter logic [DATA_W-1:0] ID1       = 8'hB9,
  parameter logic [DATA_W-1:0] VERSION   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rd_en,
  input  logic [4:0]        strap,
  output logic              led_on,
  output logic              ctl_cs,
  output logic              ctl_rd,
  output logic              ctl_wr,
  output logic [6:0]        ctl_addr,
  output logic [7:0]        ctl_wdata,
  input  logic [7:0]        ctl_rdata,
  input  logic              ctl_irq,
  output logic [2:0]        irq_oe,
  output logic [2:0]        irq_lvl
);
  logic              bank_hit;
  bank_off_e         bank_off;
  logic              win_hit;
  logic [PAGE_W-1:0] page;
  mode_t             mode;
  logic [DATA_W-1:0] bank_rdata;

  pw_addr_decode #(
    .BUS_AW(ADDR_W), .BANK_BASE(BANK_BASE), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .base_sel(strap[1:0]),
    .mode(mode), .page(page), .bank_hit(bank_hit), .bank_off(bank_off),
    .win_hit(win_hit), .ctl_addr(ctl_addr)
  );

  pw_reg_bank #(.ID0(ID0), .ID1(ID1), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && bank_hit), .off(bank_off),
    .wdata(bus_wdata), .strap(strap), .led(led_on), .page(page),
    .mode(mode), .rdata(bank_rdata)
  );

  pw_irq_route u_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(ctl_irq), .jsel(strap[4:3]),
    .share(mode.share), .irq_oe(irq_oe), .irq_lvl(irq_lvl)
  );

  always_comb begin
    ctl_cs    = win_hit;
    ctl_rd    = win_hit && bus_rd;
    ctl_wr    = win_hit && bus_wr;
    ctl_wdata = bus_wdata;
    bus_rd_en = bus_rd && (bank_hit || win_hit);
    if (!bus_rd)       bus_rdata = '0;
    else if (bank_hit) bus_rdata = bank_rdata;
    else if (win_hit)  bus_rdata = ctl_rdata;
    else               bus_rdata = '0;
  end

  // R8
  win_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cs |-> mode.win_en);
endmodule

// File: tb/pagewin_bus_decoder_bench.sv
module pagewin_bus_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rd_en;
  logic [4:0] strap = '0;
  logic       led_on;
  logic       ctl_cs, ctl_rd, ctl_wr;
  logic [6:0] ctl_addr;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata = '0;
  logic       ctl_irq = 1'b0;
  logic [2:0] irq_oe, irq_lvl;

  int errors = 0;
  int checks = 0;

  logic       m_led;
  logic [1:0] m_page;
  logic [7:0] m_mode;

  always #5 clk = ~clk;

  pagewin_bus_decoder u_pagewin_bus_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd_en(bus_rd_en), .strap(strap), .led_on(led_on), .ctl_cs(ctl_cs),
    .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_irq(ctl_irq),
    .irq_oe(irq_oe), .irq_lvl(irq_lvl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic [9:0] bank_start();
    return 10'h150 + {5'd0, strap[1:0], 3'd0};
  endfunction

  function automatic bit f_bank_hit(input logic [9:0] a);
    return a[9:3] == bank_start()[9:3];
  endfunction

  function automatic bit f_win_hit(input logic [9:0] a);
    logic [9:0] ws;
    ws = 10'h100 + {2'd0, m_mode[2:0], 5'd0};
    return m_mode[6] && (a[9:5] == ws[9:5]) && !f_bank_hit(a);
  endfunction

  function automatic logic [7:0] f_bank_read(input logic [2:0] off);
    case (off)
      3'd0: return 8'hF6;
      3'd1: return 8'hB9;
      3'd2: return 8'h03;
      3'd3: return {7'd0, m_led};
      3'd4: return {6'd0, m_page};
      3'd5: return m_mode & 8'h67;
      3'd6: return {2'b00, strap, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  // One bus cycle: drive at negedge, check mid-cycle, register update at posedge.
  task automatic access(input logic [9:0] a, input bit wr, input logic [7:0] d, input string tag);
    bit bh, wh;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = !wr; bus_wr = wr;
    #1;
    bh = f_bank_hit(a);
    wh = f_win_hit(a);
    chk(ctl_cs == wh, {tag, " R8/R9 ctl_cs"}, ctl_cs, wh);
    chk(ctl_rd == (wh && !wr) && ctl_wr == (wh && wr), {tag, " R9 strobes"},
        {ctl_rd, ctl_wr}, {wh && !wr, wh && wr});
    if (wh) begin
      chk(ctl_addr == {m_page, a[4:0]}, {tag, " R8 ctl_addr"}, ctl_addr, {m_page, a[4:0]});
      if (wr) chk(ctl_wdata == d, {tag, " R8 ctl_wdata"}, ctl_wdata, d);
    end
    if (!wr) begin
      chk(bus_rd_en == (bh || wh), {tag, " R1 bus_rd_en"}, bus_rd_en, bh || wh);
      if (bh) chk(bus_rdata == f_bank_read(a[2:0]), {tag, " R2-6 bank read"},
                  bus_rdata, f_bank_read(a[2:0]));
      else if (wh) chk(bus_rdata == ctl_rdata, {tag, " R8 window read"}, bus_rdata, ctl_rdata);
      else chk(bus_rdata == 8'h00, {tag, " R1 no hit read"}, bus_rdata, 0);
    end
    @(posedge clk);
    if (wr && bh) begin
      case (a[2:0])
        3'd3: m_led = d[0];
        3'd4: m_page = d[1:0];
        3'd5: m_mode = d & 8'h67;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    #1;
    chk(led_on == m_led, {tag, " R3 led_on"}, led_on, m_led);
  endtask

  task automatic irq_case(input logic [1:0] js, input bit sh, input bit pend);
    logic [2:0] sel, exp_oe, exp_lvl;
    strap[4:3] = js;
    access(bank_start() + 10'd5, 1'b1, {1'b0, m_mode[6], sh, 5'd0} | {5'd0, m_mode[2:0]}, "irqcfg");
    @(negedge clk);
    ctl_irq = pend;
    @(negedge clk);
    #1;
    case (js)
      2'b11: sel = 3'b001;
      2'b01: sel = 3'b010;
      2'b10: sel = 3'b100;
      default: sel = 3'b000;
    endcase
    exp_lvl = pend ? sel : 3'b000;
    exp_oe  = (sh && sel != 3'b001) ? exp_lvl : sel;
    chk(irq_oe == exp_oe, sh ? "R11 irq_oe" : "R10 irq_oe", irq_oe, exp_oe);
    chk(irq_lvl == exp_lvl, sh ? "R11 irq_lvl" : "R10 irq_lvl", irq_lvl, exp_lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_led = 1'b0; m_page = 2'd0; m_mode = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7 reset state
    chk(led_on == 1'b0, "R7 led after reset", led_on, 0);
    chk(ctl_cs == 1'b0, "R7 window closed", ctl_cs, 0);
    for (int o = 0; o < 8; o++) access(10'h150 + 10'(o), 1'b0, 8'h00, "R7 reset read");

    // R2 R6 writes to read-only offsets have no effect
    for (int o = 0; o < 8; o++) access(10'h150 + 10'(o), 1'b1, 8'hFF, "R2/R6 ro write");
    for (int o = 0; o < 8; o++) access(10'h150 + 10'(o), 1'b0, 8'h00, "R2 ro readback");

    // R4 R5 reserved bits
    access(10'h154, 1'b1, 8'hFF, "R4 page all ones");
    access(10'h154, 1'b0, 8'h00, "R4 page rb");
    access(10'h155, 1'b1, 8'hFF, "R5 mode all ones");
    access(10'h155, 1'b0, 8'h00, "R5 mode rb");

    // R1 each base selection, edges of the bank
    for (int s = 0; s < 4; s++) begin
      strap = {3'b101, 2'(s)};
      access(bank_start() - 10'd1, 1'b0, 8'h00, "R1 below bank");
      access(bank_start() + 10'd6, 1'b0, 8'h00, "R1/R6 strap read");
      access(bank_start() + 10'd8, 1'b0, 8'h00, "R1 above bank");
    end

    // R8 R9 window overlapping bank (select 2 covers 0x140-0x15F)
    strap = 5'd0;
    access(10'h155, 1'b1, 8'h42, "R8 mode sel2 en");
    access(10'h154, 1'b1, 8'h03, "R4 page 3");
    ctl_rdata = 8'h5A;
    access(10'h14F, 1'b0, 8'h00, "R8 window top below bank");
    access(10'h153, 1'b0, 8'h00, "R9 bank priority");
    access(10'h158, 1'b1, 8'h77, "R8 window write past bank");
    access(10'h155, 1'b1, 8'h02, "R9 disable window");
    access(10'h140, 1'b0, 8'h00, "R9 window off");

    // R10 R11 interrupt routing
    for (int js = 0; js < 4; js++)
      for (int sh = 0; sh < 2; sh++)
        for (int p = 0; p < 2; p++)
          irq_case(2'(js), sh[0], p[0]);
    ctl_irq = 1'b0;

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [9:0] a;
      if (($urandom % 16) == 0) strap = 5'($urandom);
      ctl_rdata = 8'($urandom);
      if (($urandom % 4) == 0) a = bank_start() + 10'($urandom % 8);
      else a = 10'h100 + 10'($urandom % 256);
      access(a, $urandom % 2 == 1, 8'($urandom), "rand");
    end

    summary();
    $finish;
  end
endmodule